// File: doc/BRIEF.md
# Hardware Descriptor Queue Manager

This block keeps a set of hardware packet queues whose entries are descriptor addresses. A client enqueues a descriptor by presenting its address on the push port with a queue number. It dequeues the oldest descriptor of a queue by raising the pop request with a queue number. The address comes back on the following cycle. The queues do not store addresses. Each queue is a singly linked list of descriptor indices threaded through one shared link RAM, and each queue's state is a head index, a tail index and an entry count.

A descriptor address becomes a link index through a small table of descriptor regions fixed at build time. Each region has a base address, a power-of-two descriptor size, a descriptor count and the link index of its first descriptor. The index is the start index plus the offset from the base divided by the size. On a pop the index is translated back to an address. A peek port gives any queue's entry count without side effects, and a vector of per-queue empty flags is driven continuously.

Top module: `desc_queue_mgr`

## Requirements
- R1: After reset every queue count is zero, every bit of `q_empty` is 1 and `pop_valid` is 0.
- R2: A push whose address falls inside a region adds one to the target queue's count, visible on `peek_count` in the cycle after the push.
- R3: A pop request is answered in the very next cycle with `pop_valid` high for one cycle. Descriptors leave each queue in the order they were pushed.
- R4: A pop of an empty queue answers with address 0 and leaves that queue's count and flag unchanged.
- R5: A push and a pop to the same queue in one cycle are performed pop first, then push. On an empty queue the pop answers 0 and the count becomes 1. Otherwise the pop answers the old head and the count is unchanged.
- R6: The region table has two regions. Region 0 starts at base 0x1000_0000, has 64-byte descriptors and 32 entries, and begins at link index 0. Region 1 starts at base 0x2000_0000, has 128-byte descriptors and 32 entries, and begins at link index 32. A popped address is the pushed address with the bits below the descriptor size cleared, and this holds up to the last descriptor of each region.
- R7: A push whose address lies in no region is ignored: no queue's count changes.
- R8: Driving `peek_qid` changes no queue's count or order.
- R9: Queues are independent: a push to one queue and a pop from another in the same cycle each behave as if alone.
- R10: `q_empty[i]` is 1 exactly when queue i's count is zero, and it changes in the same cycle as the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Push strobe |
| push_qid | input | 3 | Target queue of the push |
| push_addr | input | 32 | Descriptor address to enqueue |
| pop_req | input | 1 | Pop strobe |
| pop_qid | input | 3 | Queue to pop from |
| pop_valid | output | 1 | Pop response valid, one cycle after `pop_req` |
| pop_addr | output | 32 | Popped descriptor address, 0 if the queue was empty |
| peek_qid | input | 3 | Queue selected for peeking |
| peek_count | output | 7 | Entry count of the peeked queue |
| q_empty | output | 8 | Per-queue empty flags |

## Verification
A push and a pop can land on the same queue in one cycle. The link RAM must then be read for the new head while the old tail's link is written, or the push must become the first entry of a queue the pop has just drained. The bench drives both strobes together to one queue when it is empty, holds one entry and holds several entries. A reference model applies the pop before the push and decides the expected popped address and the count afterwards. A scoreboard compares every returned address in order, and the peek port and empty flags are checked against the model's queue lengths.

// File: rtl/qm_pkg.sv
package qm_pkg;
    parameter int QM_NUM_Q    = 8;
    parameter int QM_NUM_DESC = 64;
    parameter int QM_ADDR_W   = 32;
    parameter int QM_NUM_REG  = 2;
    parameter int QM_LG_W     = 5;

    localparam int QM_QID_W = $clog2(QM_NUM_Q);
    localparam int QM_IDX_W = $clog2(QM_NUM_DESC);
    localparam int QM_CNT_W = $clog2(QM_NUM_DESC + 1);

    typedef logic [QM_IDX_W-1:0]  idx_t;
    typedef logic [QM_CNT_W-1:0]  cnt_t;
    typedef logic [QM_ADDR_W-1:0] addr_t;
    typedef logic [QM_QID_W-1:0]  qid_t;

    typedef struct packed {
        addr_t               base;
        logic [QM_LG_W-1:0]  size_lg;
        cnt_t                count;
        idx_t                start;
    } region_t;

    typedef struct packed {
        idx_t head;
        idx_t tail;
        cnt_t count;
    } qent_t;

    localparam region_t QM_REGIONS [QM_NUM_REG] = '{
        '{base: 32'h1000_0000, size_lg: 5'd6, count: 7'd32, start: 6'd0},
        '{base: 32'h2000_0000, size_lg: 5'd7, count: 7'd32, start: 6'd32}
    };
endpackage

// File: rtl/qm_region_xlate.sv
module qm_region_xlate
    import qm_pkg::*;
#(
    parameter region_t REGIONS [QM_NUM_REG] = QM_REGIONS
) (
    input  addr_t fwd_addr,
    output logic  fwd_hit,
    output idx_t  fwd_idx,
    input  idx_t  rev_idx,
    output addr_t rev_addr
);
    localparam int W = QM_CNT_W + 1;

    // address -> link index, first matching region wins
    always_comb begin
        fwd_hit = 1'b0;
        fwd_idx = '0;
        for (int r = 0; r < QM_NUM_REG; r++) begin
            addr_t off;
            addr_t slot;
            off  = fwd_addr - REGIONS[r].base;
            slot = off >> REGIONS[r].size_lg;
            if (!fwd_hit && fwd_addr >= REGIONS[r].base &&
                slot < QM_ADDR_W'(REGIONS[r].count)) begin
                fwd_hit = 1'b1;
                fwd_idx = REGIONS[r].start + QM_IDX_W'(slot);
            end
        end
    end

    // link index -> aligned descriptor address
    always_comb begin
        logic found;
        found    = 1'b0;
        rev_addr = '0;
        for (int r = 0; r < QM_NUM_REG; r++) begin
            logic [W-1:0] lo;
            logic [W-1:0] hi;
            logic [W-1:0] ix;
            lo = W'(REGIONS[r].start);
            hi = lo + W'(REGIONS[r].count);
            ix = W'(rev_idx);
            if (!found && ix >= lo && ix < hi) begin
                found    = 1'b1;
                rev_addr = REGIONS[r].base +
                           (QM_ADDR_W'(ix - lo) << REGIONS[r].size_lg);
            end
        end
    end
endmodule

// File: rtl/qm_link_ram.sv
module qm_link_ram
    import qm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic we,
    input  idx_t waddr,
    input  idx_t wdata,
    input  idx_t raddr,
    output idx_t rdata
);
    idx_t mem_q [QM_NUM_DESC];
    idx_t mem_d [QM_NUM_DESC];

    always_comb begin
        mem_d = mem_q;
        if (we) mem_d[waddr] = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < QM_NUM_DESC; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/qm_queue_state.sv
module qm_queue_state
    import qm_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push_ok,
    input  qid_t                         push_qid,
    input  idx_t                         push_idx,
    input  logic                         pop_req,
    input  qid_t                         pop_qid,
    input  idx_t                         link_rdata,
    output idx_t                         link_raddr,
    output logic                         link_we,
    output idx_t                         link_waddr,
    output idx_t                         link_wdata,
    output logic                         pop_hit,
    output idx_t                         pop_idx,
    output logic [QM_NUM_Q-1:0]          empty_o,
    output logic [QM_NUM_Q-1:0][QM_CNT_W-1:0] cnt_o
);
    typedef struct packed {
        qent_t [QM_NUM_Q-1:0] q;
        logic  [QM_NUM_Q-1:0] empty;
    } st_t;

    st_t st_d, st_q;

    assign link_raddr = st_q.q[pop_qid].head;
    assign pop_idx    = st_q.q[pop_qid].head;

    always_comb begin
        qent_t cur;
        st_d       = st_q;
        pop_hit    = pop_req && (st_q.q[pop_qid].count != '0);
        link_we    = 1'b0;
        link_waddr = '0;
        link_wdata = '0;

        // pop is applied first
        if (pop_hit) begin
            st_d.q[pop_qid].count = st_q.q[pop_qid].count - 1'b1;
            if (st_q.q[pop_qid].count != cnt_t'(1))
                st_d.q[pop_qid].head = link_rdata;
        end

        // then the push, seeing the post-pop state
        cur = st_d.q[push_qid];
        if (push_ok) begin
            if (cur.count == '0) begin
                cur.head  = push_idx;
                cur.tail  = push_idx;
                cur.count = cnt_t'(1);
            end else begin
                link_we    = 1'b1;
                link_waddr = cur.tail;
                link_wdata = push_idx;
                cur.tail   = push_idx;
                cur.count  = cur.count + 1'b1;
            end
            st_d.q[push_qid] = cur;
        end

        for (int i = 0; i < QM_NUM_Q; i++)
            st_d.empty[i] = (st_d.q[i].count == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{default: '0, empty: '1};
        else        st_q <= st_d;
    end

    always_comb begin
        for (int i = 0; i < QM_NUM_Q; i++) cnt_o[i] = st_q.q[i].count;
    end
    assign empty_o = st_q.empty;

    generate
        for (genvar g = 0; g < QM_NUM_Q; g++) begin : g_chk
            AST_EMPTY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
                empty_o[g] == (cnt_o[g] == '0)); // R10
            AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
                cnt_o[g] <= cnt_t'(QM_NUM_DESC)); // R2
        end
    endgenerate

    AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok && !(pop_req && pop_qid == push_qid))
        |=> cnt_o[$past(push_qid)] == $past(cnt_o[push_qid]) + 1'b1); // R2

    AST_SAME_Q_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok && pop_req && pop_qid == push_qid && cnt_o[push_qid] != '0)
        |=> $stable(cnt_o)); // R5
endmodule

// File: rtl/desc_queue_mgr.sv
module desc_queue_mgr
    import qm_pkg::*;
#(
    parameter region_t REGIONS [QM_NUM_REG] = QM_REGIONS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 push_valid,
    input  logic [QM_QID_W-1:0]  push_qid,
    input  logic [QM_ADDR_W-1:0] push_addr,
    input  logic                 pop_req,
    input  logic [QM_QID_W-1:0]  pop_qid,
    output logic                 pop_valid,
    output logic [QM_ADDR_W-1:0] pop_addr,
    input  logic [QM_QID_W-1:0]  peek_qid,
    output logic [QM_CNT_W-1:0]  peek_count,
    output logic [QM_NUM_Q-1:0]  q_empty
);
    typedef struct packed {
        logic  valid;
        addr_t addr;
    } rsp_t;

    rsp_t  rsp_d, rsp_q;
    logic  fwd_hit, pop_hit, link_we;
    idx_t  fwd_idx, pop_idx, link_raddr, link_rdata, link_waddr, link_wdata;
    addr_t rev_addr;
    logic [QM_NUM_Q-1:0][QM_CNT_W-1:0] cnt;

    qm_region_xlate #(.REGIONS(REGIONS)) u_xlate (
        .fwd_addr (push_addr),
        .fwd_hit  (fwd_hit),
        .fwd_idx  (fwd_idx),
        .rev_idx  (pop_idx),
        .rev_addr (rev_addr)
    );

    qm_link_ram u_link (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (link_we),
        .waddr (link_waddr),
        .wdata (link_wdata),
        .raddr (link_raddr),
        .rdata (link_rdata)
    );

    qm_queue_state u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_ok    (push_valid && fwd_hit),
        .push_qid   (push_qid),
        .push_idx   (fwd_idx),
        .pop_req    (pop_req),
        .pop_qid    (pop_qid),
        .link_rdata (link_rdata),
        .link_raddr (link_raddr),
        .link_we    (link_we),
        .link_waddr (link_waddr),
        .link_wdata (link_wdata),
        .pop_hit    (pop_hit),
        .pop_idx    (pop_idx),
        .empty_o    (q_empty),
        .cnt_o      (cnt)
    );

    always_comb begin
        rsp_d.valid = pop_req;
        rsp_d.addr  = pop_hit ? rev_addr : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign pop_valid  = rsp_q.valid;
    assign pop_addr   = rsp_q.addr;
    assign peek_count = cnt[peek_qid];

    AST_POP_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
        pop_req |=> pop_valid); // R3
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !pop_req |=> !pop_valid); // R3
    AST_EMPTY_POP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && q_empty[pop_qid]) |=> (pop_addr == '0)); // R4
    AST_BAD_PUSH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && !fwd_hit && !pop_req) |=> $stable(cnt)); // R7
endmodule

// File: tb/sim_desc_queue_mgr.sv
module sim_desc_queue_mgr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_valid = 1'b0;
    logic [2:0]  push_qid = '0;
    logic [31:0] push_addr = '0;
    logic        pop_req = 1'b0;
    logic [2:0]  pop_qid = '0;
    logic        pop_valid;
    logic [31:0] pop_addr;
    logic [2:0]  peek_qid = '0;
    logic [6:0]  peek_count;
    logic [7:0]  q_empty;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] mdl [8][$];
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #5 clk = ~clk;

    desc_queue_mgr u0 (.*);

    // R6 region table as stated in the requirement
    function automatic bit in_region(input logic [31:0] a, output logic [31:0] al);
        al = 32'h0;
        if (a >= 32'h1000_0000 && a < 32'h1000_0000 + 32 * 64) begin
            al = a & ~32'h3F; return 1;
        end
        if (a >= 32'h2000_0000 && a < 32'h2000_0000 + 32 * 128) begin
            al = a & ~32'h7F; return 1;
        end
        return 0;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // driver: one cycle of stimulus, expectation pushed into the scoreboard
    task automatic op(input bit pv, input int pq, input logic [31:0] pa,
                      input bit rv, input int rq, input string tag);
        logic [31:0] e, al;
        @(negedge clk);
        push_valid = pv; push_qid = 3'(pq); push_addr = pa;
        pop_req = rv; pop_qid = 3'(rq);
        if (rv) begin
            e = (mdl[rq].size() > 0) ? mdl[rq].pop_front() : 32'h0;
            exp_q.push_back(e); tag_q.push_back(tag);
        end
        if (pv && in_region(pa, al)) mdl[pq].push_back(al);
        @(negedge clk);
        push_valid = 1'b0; pop_req = 1'b0;
    endtask

    // monitor: compares every response against the scoreboard
    always @(negedge clk) begin
        if (rst_n && pop_valid) begin
            if (exp_q.size() == 0) begin
                chk(0, "R3 unexpected response", pop_addr, 32'h0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front(); t = tag_q.pop_front();
                chk(pop_addr === e, t, pop_addr, e);
            end
        end
    end

    task automatic check_state(input string tag);
        @(negedge clk);
        for (int q = 0; q < 8; q++) begin
            peek_qid = 3'(q);
            #1;
            chk(peek_count == 7'(mdl[q].size()), {tag, " count"}, 32'(peek_count), 32'(mdl[q].size()));
            chk(q_empty[q] == (mdl[q].size() == 0), {tag, " R10 empty"}, 32'(q_empty[q]), 32'(mdl[q].size() == 0));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(pop_valid == 1'b0, "R1 pop_valid", 32'(pop_valid), 0);
        chk(q_empty == 8'hFF, "R1 empty", 32'(q_empty), 32'hFF);
        check_state("R1");

        // R2, R3, R6: region 0 with unaligned low bits, FIFO order
        op(1, 0, 32'h1000_0005, 0, 0, "");
        op(1, 0, 32'h1000_0040, 0, 0, "");
        op(1, 0, 32'h1000_07FF, 0, 0, "");
        check_state("R2");
        op(0, 0, 0, 1, 0, "R3 fifo 1");
        op(0, 0, 0, 1, 0, "R3 fifo 2");
        op(0, 0, 0, 1, 0, "R6 last of region 0");
        // R4 empty pop
        op(0, 0, 0, 1, 0, "R4 empty pop");
        check_state("R4");

        // R6 region 1 boundaries
        op(1, 3, 32'h2000_0000, 0, 0, "");
        op(1, 3, 32'h2000_0F80, 0, 0, "");
        op(1, 3, 32'h2000_0123, 0, 0, "");
        check_state("R6");

        // R7 out-of-region pushes
        op(1, 5, 32'h1000_0800, 0, 0, "");
        op(1, 5, 32'h0FFF_FFC0, 0, 0, "");
        op(1, 5, 32'h2000_1000, 0, 0, "");
        op(1, 5, 32'h0000_0000, 0, 0, "");
        check_state("R7");
        op(0, 0, 0, 1, 5, "R7 nothing queued");

        // R5 same-queue push and pop
        op(1, 6, 32'h1000_0100, 1, 6, "R5 empty queue");
        check_state("R5 empty");
        op(1, 6, 32'h1000_0140, 1, 6, "R5 one entry");
        check_state("R5 one");
        op(1, 6, 32'h1000_0180, 0, 0, "");
        op(1, 6, 32'h1000_01C0, 0, 0, "");
        op(1, 6, 32'h2000_0200, 1, 6, "R5 several entries");
        check_state("R5 several");

        // R9 push one queue while popping another
        op(1, 1, 32'h1000_0300, 1, 3, "R9 cross pop 1");
        op(1, 1, 32'h1000_0340, 1, 3, "R9 cross pop 2");
        check_state("R9");

        // R8 peek sweep must not disturb anything
        for (int k = 0; k < 16; k++) begin
            @(negedge clk); peek_qid = 3'(k);
        end
        check_state("R8");

        // drain everything
        for (int q = 0; q < 8; q++)
            for (int n = 0; n < 4; n++) op(0, 0, 0, 1, q, "R3 drain");
        check_state("R3 drained");

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R3 missing responses", 32'(exp_q.size()), 0);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule